// File: doc/BRIEF.md
# SMBus Clock-Line Timeout Monitor

This block sits beside an SMBus master and watches the sampled level of the clock line. It runs two timers that can be switched on separately. The stuck-low timer counts time base ticks while a transaction is in progress and the clock line is low. When the line has been low for longer than the configured limit, the block asks the master to abort and records the cause in a status code. The idle timer counts ticks while the clock line is high. Once the line has been high for long enough, the block reports the bus as free.

Both limits are parameters counted in ticks of a time base enable. That tick is a single-cycle strobe made by the surrounding logic, for example one per microsecond. A pulse on `xfer_start` marks the start of each individual transfer. It clears both timers, the abort record and the stored status. When idle detection is switched off, the bus-free flag instead follows a flag that a STOP indication from the master sets and the next transfer start clears.

Top module: `smbus_timeout_mon`

## Requirements
- R1: With `low_to_en`=1, `xfer_active`=1 and `scl_in`=0, the stuck-low count rises by one at each clock edge where `tick_en`=1, and stops rising at `LOW_LIMIT`. `abort_req` is high in the cycle after the edge at which a tick is sampled while the count already equals `LOW_LIMIT`. That tick is the (`LOW_LIMIT`+1)th consecutive low tick.
- R2: `abort_req` is a pulse one cycle wide. It fires at most once between two `xfer_start` pulses, even if the clock line stays low.
- R3: `status_code` is 2'b00 (no fault) after reset. It becomes 2'b01 (stuck-low timeout) in the same cycle as `abort_req`, and it keeps that value until an `xfer_start` pulse returns it to 2'b00.
- R4: The stuck-low count returns to zero at any edge where `scl_in`=1, `xfer_active`=0 or `low_to_en`=0. The next timeout therefore needs a fresh unbroken run of low ticks.
- R5: While `low_to_en`=0, `abort_req` stays low and `status_code` does not change.
- R6: With `free_det_en`=1, `bus_free` is 1 exactly while the idle count equals `FREE_LIMIT`. The idle count rises by one per tick sampled with `scl_in`=1, stops at the limit, and clears at any edge where `scl_in`=0. `bus_free` is therefore low in the cycle after a low sample.
- R7: With `free_det_en`=0, the idle count is held at zero. `bus_free` then shows a flag that a `stop_seen` pulse sets and an `xfer_start` pulse clears, with start taking priority. The flag is 0 after reset.
- R8: A pulse on `xfer_start` clears both counts, whatever the other inputs are.
- R9: Neither count changes at an edge where `tick_en`=0, unless that edge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Time base strobe; one count per high cycle |
| scl_in | input | 1 | Synchronised clock-line level |
| xfer_active | input | 1 | Master is inside a transaction |
| xfer_start | input | 1 | Pulse at the start of each transfer |
| stop_seen | input | 1 | Pulse when the master completes a STOP |
| low_to_en | input | 1 | Enables the stuck-low timer |
| free_det_en | input | 1 | Enables idle-time bus-free detection |
| abort_req | output | 1 | One-cycle request to terminate the transaction |
| status_code | output | 2 | Termination cause: 00 none, 01 stuck-low timeout |
| bus_free | output | 1 | Bus treated as free |

## Verification
The bench contains a reference model that takes the same sampled inputs at each rising edge. Its expected value for `abort_req` and `status_code` applies from the cycle after that edge, because each of these comes from one register stage. `bus_free` is also due one cycle after the edge that updates the idle count or the STOP flag, but it follows `free_det_en` without delay. The bench drives every input shortly after a rising edge and compares all three outputs at the falling edge, where registered and combinational values have settled. Targeted checks in each scenario then confirm that no abort was missed, none was repeated and none appeared where it should not.

// File: rtl/smbus_tmo_pkg.sv
package smbus_tmo_pkg;
   localparam int STATUS_W = 2;
   typedef enum logic [STATUS_W-1:0] {
      TMO_NONE    = 2'b00,
      TMO_SCL_LOW = 2'b01
   } tmo_status_e;
endpackage

// File: rtl/tmo_run_counter.sv
module tmo_run_counter #(
   parameter int LIMIT = 25000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic at_lim
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("tmo_run_counter: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (clr)               cnt_q <= '0;
      else if (inc && !at_lim)    cnt_q <= cnt_q + 1'b1;
   end

   assign at_lim = (cnt_q == LIM_V);

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0)); // R4
   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr) |=> $stable(cnt_q)); // R9
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      at_lim && !clr |=> at_lim); // R1
endmodule

// File: rtl/tmo_status.sv
module tmo_status
   import smbus_tmo_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                xfer_start,
   input  logic                trip_cand,
   input  logic                stop_seen,
   output logic                abort_req,
   output logic [STATUS_W-1:0] status_code,
   output logic                stop_flag
);
   tmo_status_e st_q;
   logic        tripped_q;
   logic        fire;

   assign fire = trip_cand && !tripped_q && !xfer_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= TMO_NONE;
         tripped_q <= 1'b0;
         abort_req <= 1'b0;
         stop_flag <= 1'b0;
      end else begin
         abort_req <= fire;
         if (xfer_start) begin
            st_q      <= TMO_NONE;
            tripped_q <= 1'b0;
         end else if (fire) begin
            st_q      <= TMO_SCL_LOW;
            tripped_q <= 1'b1;
         end
         if (xfer_start)     stop_flag <= 1'b0;
         else if (stop_seen) stop_flag <= 1'b1;
      end
   end

   assign status_code = st_q;

   AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req |=> !abort_req); // R2
   AST_STATUS_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req |-> (status_code == TMO_SCL_LOW)); // R3
   AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> (status_code == TMO_NONE)); // R3
endmodule

// File: rtl/smbus_timeout_mon.sv
module smbus_timeout_mon
   import smbus_tmo_pkg::*;
#(
   parameter int LOW_LIMIT  = 25000,
   parameter int FREE_LIMIT = 50
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_en,
   input  logic                scl_in,
   input  logic                xfer_active,
   input  logic                xfer_start,
   input  logic                stop_seen,
   input  logic                low_to_en,
   input  logic                free_det_en,
   output logic                abort_req,
   output logic [STATUS_W-1:0] status_code,
   output logic                bus_free
);
   generate
      if (LOW_LIMIT < 1 || FREE_LIMIT < 1) begin : g_bad_params
         $error("smbus_timeout_mon: limits must be at least 1");
      end
   endgenerate

   logic lo_clr, lo_at_lim, hi_clr, hi_at_lim, trip_cand, stop_flag;

   assign lo_clr = xfer_start || !low_to_en || scl_in || !xfer_active;
   assign hi_clr = xfer_start || !free_det_en || !scl_in;

   tmo_run_counter #(.LIMIT(LOW_LIMIT)) u_low_cnt (
      .clk(clk), .rst_n(rst_n), .clr(lo_clr), .inc(tick_en), .at_lim(lo_at_lim)
   );

   tmo_run_counter #(.LIMIT(FREE_LIMIT)) u_high_cnt (
      .clk(clk), .rst_n(rst_n), .clr(hi_clr), .inc(tick_en), .at_lim(hi_at_lim)
   );

   assign trip_cand = low_to_en && xfer_active && !scl_in && tick_en && lo_at_lim;

   tmo_status u_status (
      .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .trip_cand(trip_cand),
      .stop_seen(stop_seen), .abort_req(abort_req), .status_code(status_code),
      .stop_flag(stop_flag)
   );

   assign bus_free = free_det_en ? hi_at_lim : stop_flag;

   AST_NO_ABORT_DIS: assert property (@(posedge clk) disable iff (!rst_n)
      !low_to_en |=> !abort_req); // R5
   AST_STATUS_HOLD_DIS: assert property (@(posedge clk) disable iff (!rst_n)
      (!low_to_en && !xfer_start) |=> $stable(status_code)); // R5
   AST_FREE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (free_det_en && !scl_in) |=> (!bus_free || !free_det_en)); // R6
endmodule

// File: tb/tb_smbus_timeout_mon.sv
module tb_smbus_timeout_mon;
   localparam int LOW_LIM  = 20;
   localparam int FREE_LIM = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic tick_en = 1'b1, scl_in = 1'b1, xfer_active = 1'b0, xfer_start = 1'b0;
   logic stop_seen = 1'b0, low_to_en = 1'b0, free_det_en = 1'b0;
   logic half_rate = 1'b0;
   logic abort_req, bus_free;
   logic [1:0] status_code;

   int tests = 0, fails = 0, ab_cnt = 0, cyc = 0;
   int m_lo = 0, m_hi = 0, m_trip = 0, m_stat = 0, m_stop = 0, m_abort = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   smbus_timeout_mon #(.LOW_LIMIT(LOW_LIM), .FREE_LIMIT(FREE_LIM)) dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .scl_in(scl_in),
      .xfer_active(xfer_active), .xfer_start(xfer_start), .stop_seen(stop_seen),
      .low_to_en(low_to_en), .free_det_en(free_det_en), .abort_req(abort_req),
      .status_code(status_code), .bus_free(bus_free)
   );

   // tick generator: every cycle, or every other cycle in half-rate mode
   always @(posedge clk) begin
      #1;
      tick_en = half_rate ? ~tick_en : 1'b1;
   end

   // behavioural reference model
   always @(posedge clk) begin
      bit fire;
      if (!rst_n) begin
         m_lo = 0; m_hi = 0; m_trip = 0; m_stat = 0; m_stop = 0; m_abort = 0;
      end else begin
         fire = low_to_en && xfer_active && !scl_in && tick_en &&
                (m_lo == LOW_LIM) && (m_trip == 0) && !xfer_start;
         m_abort = fire ? 1 : 0;
         if (xfer_start) begin m_stat = 0; m_trip = 0; end
         else if (fire)  begin m_stat = 1; m_trip = 1; end
         if (xfer_start || !low_to_en || scl_in || !xfer_active) m_lo = 0;
         else if (tick_en && m_lo < LOW_LIM) m_lo++;
         if (xfer_start || !free_det_en || !scl_in) m_hi = 0;
         else if (tick_en && m_hi < FREE_LIM) m_hi++;
         if (xfer_start) m_stop = 0;
         else if (stop_seen) m_stop = 1;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at t=%0t", req, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R1/R2 abort_req", int'(abort_req), m_abort);
         chk("R3 status_code", int'(status_code), m_stat);
         chk("R6/R7 bus_free", int'(bus_free),
             free_det_en ? ((m_hi == FREE_LIM) ? 1 : 0) : m_stop);
         if (abort_req) ab_cnt++;
      end
   end

   task automatic step(input int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic start_pulse();
      xfer_start = 1'b1; step(1); xfer_start = 1'b0;
   endtask

   initial begin
      fork
         begin : watchdog
            repeat (20000) @(posedge clk);
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
         end
      join_none

      step(3);
      @(negedge clk);
      chk("R3 reset status", int'(status_code), 0);
      chk("R7 reset bus_free", int'(bus_free), 0);
      chk("R2 reset abort", int'(abort_req), 0);
      rst_n = 1'b1;
      step(2);

      // R1/R2/R3: stuck-low timeout fires once and status persists
      low_to_en = 1'b1; xfer_active = 1'b1; start_pulse();
      ab_cnt = 0; scl_in = 1'b0; step(40);
      chk("R1 one abort after long low", ab_cnt, 1);
      chk("R3 status holds timeout", int'(status_code), 1);
      step(5);
      chk("R2 no repeat abort", ab_cnt, 1);
      start_pulse();
      @(negedge clk);
      chk("R3/R8 start clears status", int'(status_code), 0);
      step(1);

      // R4: a single high sample restarts the run
      ab_cnt = 0;
      scl_in = 1'b0; step(15); scl_in = 1'b1; step(1); scl_in = 1'b0; step(15);
      chk("R4 high sample restarts count", ab_cnt, 0);
      scl_in = 1'b1; step(1);

      // R5: timer disabled
      low_to_en = 1'b0; ab_cnt = 0; scl_in = 1'b0; step(40);
      chk("R5 disabled no abort", ab_cnt, 0);
      chk("R5 status unchanged", int'(status_code), 0);

      // R4: no transaction active
      low_to_en = 1'b1; xfer_active = 1'b0; step(40);
      chk("R4 inactive no abort", ab_cnt, 0);

      // R9: half-rate ticks stretch the limit
      scl_in = 1'b1; xfer_active = 1'b1; half_rate = 1'b1; start_pulse();
      scl_in = 1'b0; step(30);
      chk("R9 no abort before enough ticks", ab_cnt, 0);
      step(20);
      chk("R9 abort after enough ticks", ab_cnt, 1);
      half_rate = 1'b0; scl_in = 1'b1; xfer_active = 1'b0; start_pulse();
      low_to_en = 1'b0;

      // R6: idle detection
      free_det_en = 1'b1; step(FREE_LIM + 3);
      @(negedge clk);
      chk("R6 bus free after idle", int'(bus_free), 1);
      step(1); scl_in = 1'b0; step(1);
      @(negedge clk);
      chk("R6 low sample clears free", int'(bus_free), 0);
      scl_in = 1'b1; step(4);
      @(negedge clk);
      chk("R6 not free before limit", int'(bus_free), 0);
      step(FREE_LIM + 2);
      start_pulse();
      @(negedge clk);
      chk("R8 start clears idle count", int'(bus_free), 0);
      step(1);

      // R7: STOP-based bus free
      free_det_en = 1'b0;
      @(negedge clk);
      chk("R7 flag clear before stop", int'(bus_free), 0);
      step(1); stop_seen = 1'b1; step(1); stop_seen = 1'b0;
      @(negedge clk);
      chk("R7 stop sets bus_free", int'(bus_free), 1);
      step(2);
      start_pulse();
      @(negedge clk);
      chk("R7 start clears stop flag", int'(bus_free), 0);
      step(3);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule